// File: doc/BRIEF.md
# Post-Increment Store Address Unit

This block carries out register-indirect stores with automatic address advance, in byte and halfword sizes. When it takes a command it reads two registers through a register-file read port: the data register and the address register. It then presents one write request to a memory port that uses a valid/ready handshake. The request carries the address, a size flag, byte enables and lane-replicated data. Only after the memory port accepts the write does the block return the advanced address to the address register, through a register-file write port.

The address is copied at its full width when the command is taken, and the increment is computed from that copy. As a result, the store always uses the original address. The advance is a full-width addition, so a carry out of the low byte or the low halfword moves into the upper address bits. If the data register and the address register are the same register, the stored data is the value from before the advance. Command decode, alignment faults and hazard forwarding are handled outside this block.

Top module: `pinc_store_unit`

## Requirements
- R1: A byte store (cmd_half=0) requests address A, the pre-increment value of the address register, with mem_half=0. mem_be has the single bit A[1:0] set, and each of the four byte lanes of mem_wdata holds bits [7:0] of the data register.
- R2: A halfword store (cmd_half=1) requests address A with mem_half=1. mem_be is 4'b0011 when A[1]=0 and 4'b1100 when A[1]=1; A[0] does not affect the lanes. Both halfword lanes of mem_wdata hold bits [15:0] of the data register.
- R3: The value written back is A+1 for a byte store and A+2 for a halfword store, computed across all 32 bits modulo 2^32. Carries out of bit 7 and bit 15 reach the upper bits.
- R4: When the data and address register indices are equal, the stored data comes from the register value before the increment.
- R5: rf_we is high for exactly one cycle, the cycle right after mem_valid and mem_ready are both high, with rf_wa equal to the command's address register index.
- R6: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_addr, mem_be and mem_wdata stay unchanged.
- R7: busy is low when idle. It goes high in the cycle after a command is accepted and stays high through the writeback cycle.
- R8: A cmd_valid seen while busy is high is ignored: it causes no memory request and no register write.
- R9: After reset, busy, mem_valid and rf_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_half | input | 1 | 1 = halfword store, 0 = byte store |
| cmd_src_idx | input | 5 | Data register index |
| cmd_adr_idx | input | 5 | Address register index |
| busy | output | 1 | Command in progress |
| rf_src_idx | output | 5 | Read port index for data register |
| rf_adr_idx | output | 5 | Read port index for address register |
| rf_src_val | input | 32 | Data register value |
| rf_adr_val | input | 32 | Address register value |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Write address (pre-increment) |
| mem_half | output | 1 | 1 = halfword, 0 = byte |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| rf_we | output | 1 | Register writeback strobe |
| rf_wa | output | 5 | Writeback register index |
| rf_wd | output | 32 | Incremented address |

## Verification
The bench targets the address edges where the advance carries: 0x000000FF for a byte store, 0x0000FFFE for a halfword store, and 0xFFFFFFFF, which must wrap to zero. An adder cut to 8 or 16 bits would write back 0x00000000 or lose the carry into bit 16. It stores with one register serving as both data and address, where a design that wrote back first would store the advanced value. It stalls the memory port for several cycles while offering a second command. A design that wrote back early, dropped the request, or took the second command would show a register change or an extra memory write.

// File: rtl/psu_pkg.sv
package psu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WB    = 2'd2
  } psu_state_e;
endpackage

// File: rtl/psu_ctrl.sv
module psu_ctrl
  import psu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic mem_ready,
  output logic accept,
  output logic mem_valid,
  output logic wb_en,
  output logic busy
);
  psu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = ST_WRITE;
      ST_WRITE: if (mem_ready) state_d = ST_WB;
      ST_WB:    state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept    = (state_q == ST_IDLE) && cmd_valid;
  assign mem_valid = (state_q == ST_WRITE);
  assign wb_en     = (state_q == ST_WB);
  assign busy      = (state_q != ST_IDLE);

  // R5
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);
  // R5
  wb_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(mem_valid && mem_ready));
  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && mem_valid);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid);
endmodule

// File: rtl/psu_incr.sv
module psu_incr #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              half,
  output logic [ADDR_W-1:0] next
);
  logic [ADDR_W-1:0] step;
  assign step = half ? ADDR_W'(2) : ADDR_W'(1);
  assign next = base + step;
endmodule

// File: rtl/psu_lanes.sv
module psu_lanes #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                half,
  input  logic [DATA_W-1:0]   src,
  output logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0]   wdata
);
  localparam int LANES = DATA_W / 8;
  localparam int LSB   = $clog2(LANES);

  logic [LSB-1:0] byte_sel;
  logic [LSB-1:0] pair_sel;
  assign byte_sel = addr[LSB-1:0];
  assign pair_sel = byte_sel >> 1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = half ? (pair_sel == LSB'(i / 2)) : (byte_sel == LSB'(i));
    assign wdata[8*i +: 8] = half ? src[8*(i % 2) +: 8] : src[7:0];
  end
endmodule

// File: rtl/pinc_store_unit.sv
module pinc_store_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RIDX_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic                cmd_half,
  input  logic [RIDX_W-1:0]   cmd_src_idx,
  input  logic [RIDX_W-1:0]   cmd_adr_idx,
  output logic                busy,
  output logic [RIDX_W-1:0]   rf_src_idx,
  output logic [RIDX_W-1:0]   rf_adr_idx,
  input  logic [DATA_W-1:0]   rf_src_val,
  input  logic [ADDR_W-1:0]   rf_adr_val,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_half,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                rf_we,
  output logic [RIDX_W-1:0]   rf_wa,
  output logic [ADDR_W-1:0]   rf_wd
);
  localparam int LANES = DATA_W / 8;

  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic accept;

  psu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .cmd_valid (cmd_valid),
    .mem_ready (mem_ready),
    .accept    (accept),
    .mem_valid (mem_valid),
    .wb_en     (rf_we),
    .busy      (busy)
  );

  assign rf_src_idx = cmd_src_idx;
  assign rf_adr_idx = cmd_adr_idx;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              half_q;
  logic [RIDX_W-1:0] areg_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q <= '0;
      data_q <= '0;
      half_q <= 1'b0;
      areg_q <= '0;
    end else if (accept) begin
      addr_q <= rf_adr_val;
      data_q <= rf_src_val;
      half_q <= cmd_half;
      areg_q <= cmd_adr_idx;
    end
  end

  psu_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
    .addr  (addr_q),
    .half  (half_q),
    .src   (data_q),
    .be    (mem_be),
    .wdata (mem_wdata)
  );

  psu_incr #(.ADDR_W(ADDR_W)) u_incr (
    .base (addr_q),
    .half (half_q),
    .next (rf_wd)
  );

  assign mem_addr = addr_q;
  assign mem_half = half_q;
  assign rf_wa    = areg_q;

  // R6
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)));
  // R3
  wb_value_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rf_we |-> (rf_wd - $past(mem_addr)) == ($past(mem_half) ? ADDR_W'(2) : ADDR_W'(1)));
  // R1
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_valid |-> $countones(mem_be) == (mem_half ? 2 : 1));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy |-> (!mem_valid && !rf_we));
  initial assert (LANES >= 4) else $error("data bus must be at least 32 bits");
endmodule

// File: tb/sim_pinc_store_unit.sv
module sim_pinc_store_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_half, mem_ready;
  logic [4:0]  cmd_src_idx, cmd_adr_idx;
  logic        busy, mem_valid, mem_half, rf_we;
  logic [4:0]  rf_src_idx, rf_adr_idx, rf_wa;
  logic [31:0] rf_src_val, rf_adr_val, mem_addr, mem_wdata, rf_wd;
  logic [3:0]  mem_be;

  logic [31:0] rf [32];
  int hs_count = 0;
  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_src_val = rf[rf_src_idx];
  assign rf_adr_val = rf[rf_adr_idx];

  always @(posedge clk) begin
    if (rf_we) rf[rf_wa] <= rf_wd;
    if (mem_valid && mem_ready) hs_count <= hs_count + 1;
  end

  pinc_store_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_half(cmd_half),
    .cmd_src_idx(cmd_src_idx), .cmd_adr_idx(cmd_adr_idx), .busy(busy),
    .rf_src_idx(rf_src_idx), .rf_adr_idx(rf_adr_idx),
    .rf_src_val(rf_src_val), .rf_adr_val(rf_adr_val),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_half(mem_half), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  // One store; stall = cycles of mem_ready low, with a second command offered meanwhile (R8)
  task automatic run_store(input logic half, input logic [4:0] s, input logic [4:0] a,
                           input int stall, input string req);
    logic [31:0] A, D, exp_wd, exp_data, keep20;
    logic [3:0]  exp_be;
    int          hs0;
    A = rf[a];
    D = rf[s];
    keep20 = rf[20];
    exp_wd = half ? A + 32'd2 : A + 32'd1;
    if (half) begin
      exp_be   = A[1] ? 4'b1100 : 4'b0011;
      exp_data = {2{D[15:0]}};
    end else begin
      exp_be   = 4'b0001 << A[1:0];
      exp_data = {4{D[7:0]}};
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_half = half; cmd_src_idx = s; cmd_adr_idx = a; mem_ready = 1'b0;
    @(negedge clk);
    hs0 = hs_count;
    cmd_valid = 1'b0;
    chk("R7", "busy after accept", {31'd0, busy}, 32'd1);
    for (int k = 0; k < stall; k++) begin
      cmd_valid = 1'b1; cmd_half = 1'b0; cmd_src_idx = 5'd21; cmd_adr_idx = 5'd20;
      chk("R6", "valid in stall", {31'd0, mem_valid}, 32'd1);
      chk("R6", "addr in stall", mem_addr, A);
      chk("R5", "no wb in stall", {31'd0, rf_we}, 32'd0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(req, "mem_valid", {31'd0, mem_valid}, 32'd1);
    chk(req, "mem_addr", mem_addr, A);
    chk(req, "mem_half", {31'd0, mem_half}, {31'd0, half});
    chk(req, "mem_be", {28'd0, mem_be}, {28'd0, exp_be});
    chk(req, "mem_wdata", mem_wdata, exp_data);
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk("R5", "rf_we after hs", {31'd0, rf_we}, 32'd1);
    chk("R5", "rf_wa", {27'd0, rf_wa}, {27'd0, a});
    chk("R3", "rf_wd", rf_wd, exp_wd);
    chk("R7", "busy in wb", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R5", "rf_we one cycle", {31'd0, rf_we}, 32'd0);
    chk("R7", "busy idle", {31'd0, busy}, 32'd0);
    chk("R3", "reg updated", rf[a], exp_wd);
    chk("R8", "single handshake", hs_count - hs0, 32'd1);
    if (stall > 0 && a != 5'd20)
      chk("R8", "refused cmd no write", rf[20], keep20);
  endtask

  task automatic test_reset();
    chk("R9", "busy", {31'd0, busy}, 32'd0);
    chk("R9", "mem_valid", {31'd0, mem_valid}, 32'd0);
    chk("R9", "rf_we", {31'd0, rf_we}, 32'd0);
  endtask

  task automatic test_byte_lanes();
    for (int i = 0; i < 4; i++) begin
      rf[1] = 32'hCAFE_BEA5 + i;
      rf[2] = 32'h0000_1000 + i;
      run_store(1'b0, 5'd1, 5'd2, 0, "R1");
    end
  endtask

  task automatic test_half_lanes();
    for (int i = 0; i < 4; i++) begin
      rf[3] = 32'h1234_ABCD;
      rf[4] = 32'h0000_2000 + i;
      run_store(1'b1, 5'd3, 5'd4, 0, "R2");
    end
  endtask

  task automatic test_carry();
    rf[5] = 32'h0000_00EE; rf[6] = 32'h0000_00FF;
    run_store(1'b0, 5'd5, 5'd6, 0, "R3");
    rf[6] = 32'h0000_FFFE;
    run_store(1'b1, 5'd5, 5'd6, 0, "R3");
    rf[6] = 32'hFFFF_FFFF;
    run_store(1'b0, 5'd5, 5'd6, 0, "R3");
  endtask

  task automatic test_same_reg();
    rf[7] = 32'h1234_5678;
    run_store(1'b0, 5'd7, 5'd7, 0, "R4");
    rf[7] = 32'h0000_00FE;
    run_store(1'b1, 5'd7, 5'd7, 0, "R4");
  endtask

  task automatic test_stall();
    rf[8] = 32'h55AA_33CC; rf[9] = 32'h8000_0003; rf[20] = 32'h0BAD_F00D; rf[21] = 32'h77;
    run_store(1'b1, 5'd8, 5'd9, 4, "R6");
    run_store(1'b0, 5'd8, 5'd9, 2, "R8");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_half = 1'b0; mem_ready = 1'b0;
    cmd_src_idx = 5'd0; cmd_adr_idx = 5'd0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_byte_lanes();
    test_half_lanes();
    test_carry();
    test_same_reg();
    test_stall();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule